// File: doc/BRIEF.md
# Montgomery Multiplier with Offset-Shadow Fault Detection

This block computes a word-serial Montgomery product over a small prime field and checks its own datapath while it works. The 16-bit multiplier operand is consumed four bits at a time, least significant window first. Each window drives one Montgomery step per clock: a partial product, a quotient digit that clears the low bits, and a right shift. A second accumulator runs the same step in the same cycle. Its window value is raised by a multiple of the modulus, so it sees a different number that is congruent modulo q.

After the last window, both accumulators are reduced into [0, q). In a healthy datapath the added multiple of q drops out, so the two reduced values agree. Any disagreement sets a sticky fault flag. A test hook can XOR a mask into the primary accumulator during a chosen iteration, which lets a bench or a production self-test confirm that the detector reacts.

A client pulses `start` with both operands, waits for `done`, and reads `result` in that cycle. It reads `fault` one cycle later.

Top module: `mont_shadow_mul`

## Requirements
- R1: After reset, `result` is 0 and both `done` and `fault` are 0.
- R2: A start that is accepted (`start` high while idle) is followed by `done` high for exactly one cycle, beginning four rising edges after the accepting edge.
- R3: When `done` is high, `result` equals alpha·beta·2^-16 mod 3329 and lies in [0, 3329), for any 16-bit alpha and any beta below 3329. The result stays unchanged until the next accepted start.
- R4: The shadow accumulator applies the same Montgomery step to each window plus K·q (K = 1, q = 3329). It never exceeds its analytic bound.
- R5: When injection is disabled, `fault` stays 0 through and after every operation.
- R6: With `inj_en` high, `inj_mask` is XORed into the primary accumulator at the update of iteration `inj_iter` (0 is alpha bits 3:0, 3 is bits 15:12). A single-bit mask makes `fault` 1 in the cycle after `done`.
- R7: `fault` stays 1 until the next accepted start, which clears it.
- R8: A `start` pulse that arrives while an operation is running is ignored. It neither restarts nor alters that operation.
- R9: Each Montgomery step leaves the low four bits of both pre-shift sums at zero, so the shift by four is exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| alpha | input | 16 | Multiplier operand, split into windows |
| beta | input | 12 | Multiplicand, must be below q |
| inj_en | input | 1 | Enable test fault injection |
| inj_iter | input | 2 | Iteration that receives the mask |
| inj_mask | input | 14 | Mask XORed into the primary accumulator |
| result | output | 12 | Reduced Montgomery product |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Sticky mismatch flag |

## Verification
The assertions assume that beta is below q. The shadow bound and the result range both depend on that, and the bench only drives beta values taken from [0, q-1], including 0, 1 and q-1. They also assume the injection inputs stay steady during an operation. The bench sets those inputs before `start` and leaves them alone until after `done`. Injected masks are single bits, so the resulting difference is never a multiple of q and must reach the flag.

// File: rtl/mont_shadow_mul.sv
module mont_shadow_mul #(
  parameter int W  = 4,
  parameter int L  = 16,
  parameter int Q  = 3329,
  parameter int QW = 12,
  parameter int QP = 15,
  parameter int K  = 1,
  parameter int SW = 26
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [L-1:0]         alpha,
  input  logic [QW-1:0]        beta,
  input  logic                 inj_en,
  input  logic [$clog2(L/W)-1:0] inj_iter,
  input  logic [QW+1:0]        inj_mask,
  output logic [QW-1:0]        result,
  output logic                 done,
  output logic                 fault
);
  localparam int NWIN = L / W;
  localparam int CW   = $clog2(NWIN);
  localparam int NW   = QW + 2;
  localparam int SBND = ((2**W + K*Q) * Q) / (2**W - 1) + Q;

  logic [L-1:0]  a_sh;
  logic [QW-1:0] b_r;
  logic [NW-1:0] acc;
  logic [SW-1:0] sacc;
  logic [CW-1:0] cnt;
  logic          busy;

  logic [W-1:0]  win, mu_n, mu_s;
  logic [SW-1:0] wf, nsum, ssum;
  logic [NW-1:0] acc_nx;
  logic [QW-1:0] rn, rs;
  logic          accept;

  assign accept = start && !busy;
  assign win  = a_sh[W-1:0];
  assign wf   = SW'(win) + SW'(K*Q);

  assign mu_n = W'((SW'(acc[W-1:0]) + SW'(win) * SW'(b_r[W-1:0])) * SW'(QP));
  assign mu_s = W'((SW'(sacc[W-1:0]) + wf * SW'(b_r[W-1:0])) * SW'(QP));
  assign nsum = SW'(acc) + SW'(win) * SW'(b_r) + SW'(mu_n) * SW'(Q);
  assign ssum = sacc + wf * SW'(b_r) + SW'(mu_s) * SW'(Q);

  assign acc_nx = NW'(nsum >> W) ^ ((inj_en && cnt == inj_iter) ? inj_mask : '0);

  assign rn = QW'(acc % NW'(Q));
  assign rs = QW'(sacc % SW'(Q));
  assign result = rn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh <= '0; b_r <= '0; acc <= '0; sacc <= '0;
      cnt <= '0; busy <= 1'b0; done <= 1'b0; fault <= 1'b0;
    end else begin
      done <= busy && cnt == CW'(NWIN-1);
      if (accept) begin
        a_sh  <= alpha;
        b_r   <= beta;
        acc   <= '0;
        sacc  <= '0;
        cnt   <= '0;
        busy  <= 1'b1;
        fault <= 1'b0;
      end else begin
        if (busy) begin
          a_sh <= a_sh >> W;
          acc  <= acc_nx;
          sacc <= ssum >> W;
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(NWIN-1)) busy <= 1'b0;
        end
        if (done && rn != rs) fault <= 1'b1;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2
  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result < QW'(Q)); // R3
  AST_SHADOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sacc < SW'(SBND)); // R4
  AST_EXACT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (nsum[W-1:0] == '0 && ssum[W-1:0] == '0)); // R9
  AST_FLAG_ON_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rn != rs) |=> fault); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !accept) |=> fault); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != CW'(NWIN-1)) |=> (busy && cnt == $past(cnt) + 1'b1)); // R8
endmodule

// File: tb/mont_shadow_mul_tb.sv
module mont_shadow_mul_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 3329;

  logic clk = 0, rst_n = 0, start = 0, inj_en = 0;
  logic [15:0] alpha = 0;
  logic [11:0] beta = 0;
  logic [1:0]  inj_iter = 0;
  logic [13:0] inj_mask = 0;
  logic [11:0] result;
  logic        done, fault;
  int nchk = 0, nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mont_shadow_mul u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .alpha(alpha), .beta(beta),
    .inj_en(inj_en), .inj_iter(inj_iter), .inj_mask(inj_mask),
    .result(result), .done(done), .fault(fault));

  function automatic int expect_mont(int a, int b);
    longint x = (longint'(a) * b) % Q;
    for (int i = 0; i < 16; i++) begin
      if (x[0]) x = x + Q;
      x = x >>> 1;
    end
    return int'(x);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(int a, int b, bit want_fault);
    int e = expect_mont(a, b);
    @(negedge clk); alpha = 16'(a); beta = 12'(b); start = 1;
    @(negedge clk); start = 0;
    chk(done == 0, "R2 early done", done, 0);
    repeat (3) @(negedge clk);
    chk(done == 0, "R2 done too soon", done, 0);
    @(negedge clk);
    chk(done == 1, "R2 done missing", done, 1);
    if (!want_fault) chk(int'(result) == e, "R3 R4 R9 result", result, e);
    @(negedge clk);
    chk(done == 0, "R2 done width", done, 0);
    if (want_fault) chk(fault == 1, "R6 fault not raised", fault, 1);
    else chk(fault == 0, "R5 spurious fault", fault, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(result == 0 && done == 0 && fault == 0, "R1 reset state",
        {result, done, fault}, 0);
    rst_n = 1;

    foreach (alpha[i]) begin end
    for (int bi = 0; bi < 6; bi++) begin
      int bv;
      case (bi)
        0: bv = 0; 1: bv = 1; 2: bv = 2; 3: bv = Q - 1; 4: bv = 1234; default: bv = 2048;
      endcase
      for (int a = 0; a < 65536; a += 97) run(a, bv, 0);
      run(65535, bv, 0);
    end

    for (int it = 0; it < 4; it++)
      for (int bit_i = 0; bit_i < 14; bit_i++) begin
        inj_en = 1; inj_iter = 2'(it); inj_mask = 14'(1 << bit_i);
        run(40000 + 123 * bit_i, 777 + it, 1);
        inj_en = 0; inj_mask = 0;
        repeat (3) @(negedge clk);
        chk(fault == 1, "R7 fault not sticky", fault, 1);
        @(negedge clk); alpha = 16'd5; beta = 12'd9; start = 1;
        @(negedge clk); start = 0;
        chk(fault == 0, "R7 fault not cleared by start", fault, 0);
        repeat (4) @(negedge clk);
        chk(int'(result) == expect_mont(5, 9), "R3 after clear", result, expect_mont(5, 9));
      end

    begin
      int e = expect_mont(31337, 2500);
      @(negedge clk); alpha = 16'd31337; beta = 12'd2500; start = 1;
      @(negedge clk); start = 0;
      @(negedge clk); alpha = 16'd1; beta = 12'd1; start = 1;
      @(negedge clk); start = 0;
      @(negedge clk);
      @(negedge clk);
      chk(done == 1, "R8 done moved by ignored start", done, 1);
      chk(int'(result) == e, "R8 result altered by ignored start", result, e);
      @(negedge clk);
      chk(done == 0 && fault == 0, "R8 restarted", done, 0);
      repeat (4) @(negedge clk);
      chk(done == 0 && int'(result) == e, "R3 result held", result, e);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule